// File: doc/BRIEF.md
# Hot-Plug Slot Status and Control Register

This block holds the status and control word for a single hot-plug slot in a bridge. It has three parts. First, it shows the slot's power/connection state and the codes for its two indicators, which a command engine sets. Second, it shows the slot's sense inputs as they are now: the active-low power-fault line, the attention button, the retention-latch sensor, the 66 MHz capability bit, the two-bit presence code and the PCI-X capability code. Third, it turns edges on those inputs into sticky event bits that software clears by writing 1.

Each event bit has its own interrupt mask. The latch-sensor event and the connected power-fault event also each have a system-error mask. Two outputs go to the controller's interrupt aggregator:
- an interrupt-pending flag, raised by any unmasked event;
- a system-error-pending flag, raised only by the two system-error-capable events.

Software reads the whole word combinationally. A write updates the masks and clears the event bits whose write data is 1. Debounce and indicator blinking belong to other logic.

Top module: `slot_csr`

## Requirements
- R1: During and after reset, the register reads as follows: slot state 3 (disabled), both indicator codes 3 (off), all seven mask bits (30:24) 1, all event bits (20:16) 0, and both pending outputs low.
- R2: When `upd_en` is high, each command field (state at bits 1:0, power indicator at 3:2, attention indicator at 5:4) takes its new code if that code is nonzero and keeps its value if the code is 0. The codes are: 1 powered-only/on, 2 enabled/blink, 3 disabled/off. The register shows the result one cycle later.
- R3: The sense inputs are sampled once per clock and shown one cycle later at these bits: bit 6 the power-fault line (0 means fault), bit 7 the button, bit 8 the latch sensor (1 means open), bit 9 the 66 MHz capability, bits 11:10 presence (3 means empty) and bits 14:12 the PCI-X capability.
- R4: Three input changes set event bits. Any change of the sampled presence code sets bit 16. A rising edge of the button sets bit 18; a falling edge sets nothing. Any edge of the latch sensor sets bit 19. The event bit shows two cycles after the input changes.
- R5: A falling edge of the power-fault line sets bit 20 (connected fault) if the slot state is 2 (enabled) at that time, and sets bit 17 (isolated fault) otherwise. A rising edge sets nothing.
- R6: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. If a new event arrives in the same cycle as a clear of its bit, the bit stays set.
- R7: Every write loads bits 30:24 as masks. Bits 24 to 28 mask interrupts for events 16 to 20 in the same order. Bit 29 masks the system error from the latch-sensor event, and bit 30 masks the system error from the connected fault. Writes have no effect on bits 14:0. Bits 15, 23:21 and 31 always read 0.
- R8: `int_pend` is high exactly when some event bit at position 16+k is set and its interrupt mask at position 24+k is 0.
- R9: `serr_pend` is high exactly when bit 19 is set with bit 29 clear, or bit 20 is set with bit 30 clear. The interrupt masks have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data (masks and clear bits) |
| rd_data | output | 32 | Current register contents |
| upd_en | input | 1 | Command engine update strobe |
| upd_state | input | 2 | New slot state code, 0 keeps |
| upd_pwr_ind | input | 2 | New power indicator code, 0 keeps |
| upd_attn_ind | input | 2 | New attention indicator code, 0 keeps |
| fault_n | input | 1 | Power-fault sense, low means fault |
| button | input | 1 | Attention button sense |
| latch_open | input | 1 | Retention-latch sensor, high means open |
| cap66 | input | 1 | 66 MHz capability |
| presence | input | 2 | Presence code, 3 means empty |
| pcix_cap | input | 3 | PCI-X capability code |
| int_pend | output | 1 | Unmasked event pending |
| serr_pend | output | 1 | System-error event pending |

## Verification
Two situations are hard to reach from the ports.

The first is a new event arriving in the same cycle as software clears that event's bit. The bench changes the presence code, waits exactly one clock so that the sampled code differs from its stored copy, and drives the clear in the next cycle. The event then sets the bit in the same clock that the clear is applied, and the bench expects the bit to stay set.

The second is the split between the two power-fault events. It depends on the slot state at the moment of the edge. The bench therefore first uses the command port to move the slot to enabled and expects a connected fault. It then moves the slot to disabled and expects an isolated fault, checking the system-error output in both cases.

// File: rtl/slot_csr_pkg.sv
package slot_csr_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_EV    = 5;
    localparam int NUM_SMASK = 2;
    localparam int NUM_FLD   = 3;
    localparam int FLD_W     = 2;
    localparam int PRS_W     = 2;
    localparam int PCIX_W    = 3;

    localparam int EV_LSB    = 16;
    localparam int IMASK_LSB = 24;
    localparam int SMASK_LSB = IMASK_LSB + NUM_EV;

    // event indices, bit order is decoded by software
    localparam int EV_PRS = 0;
    localparam int EV_IPF = 1;
    localparam int EV_BTN = 2;
    localparam int EV_LAT = 3;
    localparam int EV_CPF = 4;

    // command field indices
    localparam int FLD_STATE = 0;
    localparam int FLD_PWR   = 1;
    localparam int FLD_ATTN  = 2;

    typedef enum logic [FLD_W-1:0] {
        CODE_KEEP = 2'd0,
        CODE_ONE  = 2'd1,
        CODE_TWO  = 2'd2,
        CODE_OFF  = 2'd3
    } fld_code_t;

    localparam logic [FLD_W-1:0] ST_ENABLED = CODE_TWO;

    typedef struct packed {
        logic [PCIX_W-1:0] pcix;
        logic [PRS_W-1:0]  presence;
        logic              cap66;
        logic              latch_open;
        logic              button;
        logic              fault_n;
    } sense_t;

    typedef struct packed {
        logic [PRS_W-1:0] presence;
        logic             latch_open;
        logic             button;
        logic             fault_n;
    } track_t;

    function automatic logic serr_src(input logic [NUM_EV-1:0] ev,
                                      input logic [NUM_SMASK-1:0] sm);
        return (ev[EV_LAT] & ~sm[0]) | (ev[EV_CPF] & ~sm[1]);
    endfunction

endpackage

// File: rtl/slot_sense_edge.sv
module slot_sense_edge
    import slot_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sense_t            sense_i,
    input  logic              slot_enabled,
    output sense_t            sense_q,
    output logic [NUM_EV-1:0] ev_set
);

    track_t prev_q;
    track_t cur;
    logic   fault_fall;

    assign cur = '{presence:   sense_q.presence,
                   latch_open: sense_q.latch_open,
                   button:     sense_q.button,
                   fault_n:    sense_q.fault_n};

    always_ff @(posedge clk) begin
        sense_q <= sense_i;
        if (rst) begin
            prev_q <= '{presence:   sense_i.presence,
                        latch_open: sense_i.latch_open,
                        button:     sense_i.button,
                        fault_n:    sense_i.fault_n};
        end else begin
            prev_q <= cur;
        end
    end

    assign fault_fall = prev_q.fault_n & ~cur.fault_n;

    always_comb begin
        ev_set         = '0;
        ev_set[EV_PRS] = (prev_q.presence != cur.presence);
        ev_set[EV_BTN] = cur.button & ~prev_q.button;
        ev_set[EV_LAT] = cur.latch_open ^ prev_q.latch_open;
        ev_set[EV_IPF] = fault_fall & ~slot_enabled;
        ev_set[EV_CPF] = fault_fall & slot_enabled;
    end

endmodule

// File: rtl/slot_ctl_state.sv
module slot_ctl_state
    import slot_csr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           upd_en,
    input  logic [NUM_FLD-1:0][FLD_W-1:0]  upd_fld,
    output logic [NUM_FLD-1:0][FLD_W-1:0]  fld_q
);

    for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q[f] <= CODE_OFF;
            end else if (upd_en && (upd_fld[f] != CODE_KEEP)) begin
                fld_q[f] <= upd_fld[f];
            end
        end
    end

endmodule

// File: rtl/slot_event_bank.sv
module slot_event_bank
    import slot_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EV-1:0]    ev_set,
    input  logic                 wr_en,
    input  logic [NUM_EV-1:0]    clr_bits,
    input  logic [NUM_EV-1:0]    imask_wr,
    input  logic [NUM_SMASK-1:0] smask_wr,
    output logic [NUM_EV-1:0]    ev_q,
    output logic [NUM_EV-1:0]    imask_q,
    output logic [NUM_SMASK-1:0] smask_q,
    output logic                 int_pend,
    output logic                 serr_pend
);

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst) begin
                ev_q[e]    <= 1'b0;
                imask_q[e] <= 1'b1;
            end else begin
                if (ev_set[e]) begin
                    ev_q[e] <= 1'b1;
                end else if (wr_en && clr_bits[e]) begin
                    ev_q[e] <= 1'b0;
                end
                if (wr_en) begin
                    imask_q[e] <= imask_wr[e];
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SMASK; s++) begin : g_sm
        always_ff @(posedge clk) begin
            if (rst) begin
                smask_q[s] <= 1'b1;
            end else if (wr_en) begin
                smask_q[s] <= smask_wr[s];
            end
        end
    end

    assign int_pend  = |(ev_q & ~imask_q);
    assign serr_pend = serr_src(ev_q, smask_q);

endmodule

// File: rtl/slot_csr.sv
module slot_csr
    import slot_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              upd_en,
    input  logic [FLD_W-1:0]  upd_state,
    input  logic [FLD_W-1:0]  upd_pwr_ind,
    input  logic [FLD_W-1:0]  upd_attn_ind,
    input  logic              fault_n,
    input  logic              button,
    input  logic              latch_open,
    input  logic              cap66,
    input  logic [PRS_W-1:0]  presence,
    input  logic [PCIX_W-1:0] pcix_cap,
    output logic              int_pend,
    output logic              serr_pend
);

    sense_t                          sense_in;
    sense_t                          sense_q;
    logic [NUM_EV-1:0]               ev_set;
    logic [NUM_EV-1:0]               ev_q;
    logic [NUM_EV-1:0]               imask_q;
    logic [NUM_SMASK-1:0]            smask_q;
    logic [NUM_FLD-1:0][FLD_W-1:0]   upd_fld;
    logic [NUM_FLD-1:0][FLD_W-1:0]   fld_q;
    logic                            slot_enabled;
    logic                            wr_unused;

    assign sense_in = '{pcix:       pcix_cap,
                        presence:   presence,
                        cap66:      cap66,
                        latch_open: latch_open,
                        button:     button,
                        fault_n:    fault_n};

    always_comb begin
        upd_fld            = '0;
        upd_fld[FLD_STATE] = upd_state;
        upd_fld[FLD_PWR]   = upd_pwr_ind;
        upd_fld[FLD_ATTN]  = upd_attn_ind;
    end

    assign slot_enabled = (fld_q[FLD_STATE] == ST_ENABLED);

    slot_ctl_state u_state (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (upd_en),
        .upd_fld (upd_fld),
        .fld_q   (fld_q)
    );

    slot_sense_edge u_sense (
        .clk          (clk),
        .rst          (rst),
        .sense_i      (sense_in),
        .slot_enabled (slot_enabled),
        .sense_q      (sense_q),
        .ev_set       (ev_set)
    );

    slot_event_bank u_events (
        .clk       (clk),
        .rst       (rst),
        .ev_set    (ev_set),
        .wr_en     (wr_en),
        .clr_bits  (wr_data[EV_LSB +: NUM_EV]),
        .imask_wr  (wr_data[IMASK_LSB +: NUM_EV]),
        .smask_wr  (wr_data[SMASK_LSB +: NUM_SMASK]),
        .ev_q      (ev_q),
        .imask_q   (imask_q),
        .smask_q   (smask_q),
        .int_pend  (int_pend),
        .serr_pend (serr_pend)
    );

    // write bits with no storage behind them
    assign wr_unused = ^{wr_data[EV_LSB-1:0],
                         wr_data[IMASK_LSB-1:EV_LSB+NUM_EV],
                         wr_data[REG_W-1:SMASK_LSB+NUM_SMASK]};

    always_comb begin
        rd_data                              = '0;
        rd_data[1:0]                         = fld_q[FLD_STATE];
        rd_data[3:2]                         = fld_q[FLD_PWR];
        rd_data[5:4]                         = fld_q[FLD_ATTN];
        rd_data[6]                           = sense_q.fault_n;
        rd_data[7]                           = sense_q.button;
        rd_data[8]                           = sense_q.latch_open;
        rd_data[9]                           = sense_q.cap66;
        rd_data[11:10]                       = sense_q.presence;
        rd_data[14:12]                       = sense_q.pcix;
        rd_data[EV_LSB +: NUM_EV]            = ev_q;
        rd_data[IMASK_LSB +: NUM_EV]         = imask_q;
        rd_data[SMASK_LSB +: NUM_SMASK]      = smask_q;
    end

endmodule

// File: rtl/slot_csr_chk.sv
module slot_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        upd_en,
    input logic [1:0]  upd_state,
    input logic [31:0] rd_data,
    input logic        int_pend,
    input logic        serr_pend
);

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15] == 1'b0) && (rd_data[23:21] == 3'b000) && (rd_data[31] == 1'b0));

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[1:0] != 2'd0) && (rd_data[3:2] != 2'd0) && (rd_data[5:4] != 2'd0));

    // R2
    keep_state_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && (upd_state == 2'd0)) |=> $stable(rd_data[1:0]));

    // R6
    btn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[18] && !(wr_en && wr_data[18])) |=> rd_data[18]);

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[30:24] == $past(wr_data[30:24])));

    // R8
    int_source_chk: assert property (@(posedge clk) disable iff (rst)
        int_pend |-> ((rd_data[20:16] & ~rd_data[28:24]) != 5'b0));

    // R9
    serr_source_chk: assert property (@(posedge clk) disable iff (rst)
        serr_pend |-> ((rd_data[19] && !rd_data[29]) || (rd_data[20] && !rd_data[30])));

endmodule

bind slot_csr slot_csr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .upd_en    (upd_en),
    .upd_state (upd_state),
    .rd_data   (rd_data),
    .int_pend  (int_pend),
    .serr_pend (serr_pend)
);

// File: tb/slot_csr_test.sv
module slot_csr_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        upd_en;
    logic [1:0]  upd_state;
    logic [1:0]  upd_pwr_ind;
    logic [1:0]  upd_attn_ind;
    logic        fault_n;
    logic        button;
    logic        latch_open;
    logic        cap66;
    logic [1:0]  presence;
    logic [2:0]  pcix_cap;
    logic        int_pend;
    logic        serr_pend;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slot_csr uut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .upd_en       (upd_en),
        .upd_state    (upd_state),
        .upd_pwr_ind  (upd_pwr_ind),
        .upd_attn_ind (upd_attn_ind),
        .fault_n      (fault_n),
        .button       (button),
        .latch_open   (latch_open),
        .cap66        (cap66),
        .presence     (presence),
        .pcix_cap     (pcix_cap),
        .int_pend     (int_pend),
        .serr_pend    (serr_pend)
    );

    // {state, power ind, attention ind, expected bits 5:0}
    localparam logic [11:0] CMD_VEC [0:6] = '{
        {2'd1, 2'd1, 2'd0, 6'h35},
        {2'd0, 2'd2, 2'd1, 6'h19},
        {2'd2, 2'd0, 2'd0, 6'h1A},
        {2'd0, 2'd0, 2'd2, 6'h2A},
        {2'd3, 2'd3, 2'd3, 6'h3F},
        {2'd0, 2'd0, 2'd0, 6'h3F},
        {2'd2, 2'd1, 2'd3, 6'h36}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic cmd(input logic [1:0] s, input logic [1:0] p, input logic [1:0] a);
        upd_en       = 1'b1;
        upd_state    = s;
        upd_pwr_ind  = p;
        upd_attn_ind = a;
        step();
        upd_en       = 1'b0;
        upd_state    = '0;
        upd_pwr_ind  = '0;
        upd_attn_ind = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        upd_en = 1'b0; upd_state = '0; upd_pwr_ind = '0; upd_attn_ind = '0;
        fault_n = 1'b1; button = 1'b0; latch_open = 1'b0; cap66 = 1'b0;
        presence = 2'd3; pcix_cap = 3'd0;
        repeat (3) step();
        // R1 reset state
        check("R1 reset word", rd_data, 32'h7F00_0C7F);
        check("R1 pending", {30'd0, int_pend, serr_pend}, 32'd0);
        rst = 1'b0;
        step();
        check("R1 after release", rd_data, 32'h7F00_0C7F);

        // R2 command table
        for (int i = 0; i < 7; i++) begin
            cmd(CMD_VEC[i][11:10], CMD_VEC[i][9:8], CMD_VEC[i][7:6]);
            check("R2 command fields", {26'd0, rd_data[5:0]}, {26'd0, CMD_VEC[i][5:0]});
        end

        // R3 capability sensing
        cap66 = 1'b1; pcix_cap = 3'd5;
        step();
        check("R3 cap66", {31'd0, rd_data[9]}, 32'd1);
        check("R3 pcix", {29'd0, rd_data[14:12]}, 32'd5);
        step();
        check("R3 no event", {27'd0, rd_data[20:16]}, 32'd0);

        // R7 masks load, read-only and reserved bits ignore writes
        reg_write(32'h00E0_FFFF);
        check("R7 masks cleared", {25'd0, rd_data[30:24]}, 32'd0);
        check("R7 read-only bits", {17'd0, rd_data[14:0]}, 32'h0000_5E76);
        check("R7 reserved", {28'd0, rd_data[31], rd_data[23:21]}, 32'd0);

        // R4 presence change
        presence = 2'd0;
        step(); step();
        check("R4 presence event", {31'd0, rd_data[16]}, 32'd1);
        check("R8 int on presence", {31'd0, int_pend}, 32'd1);
        check("R9 no serr on presence", {31'd0, serr_pend}, 32'd0);
        reg_write(32'h0001_0000);
        check("R6 clear presence", {31'd0, rd_data[16]}, 32'd0);
        check("R8 int drops", {31'd0, int_pend}, 32'd0);

        // R4 button edges
        button = 1'b1;
        step(); step();
        check("R4 button rise", {31'd0, rd_data[18]}, 32'd1);
        reg_write(32'h0004_0000);
        button = 1'b0;
        step(); step();
        check("R4 button fall ignored", {27'd0, rd_data[20:16]}, 32'd0);

        // R4 latch sensor, R9 and R8 masking
        latch_open = 1'b1;
        step(); step();
        check("R4 latch event", {31'd0, rd_data[19]}, 32'd1);
        check("R3 latch sense", {31'd0, rd_data[8]}, 32'd1);
        check("R9 serr on latch", {31'd0, serr_pend}, 32'd1);
        reg_write(32'h2000_0000);
        check("R9 serr masked", {31'd0, serr_pend}, 32'd0);
        check("R9 int unaffected", {31'd0, int_pend}, 32'd1);
        reg_write(32'h2800_0000);
        check("R8 int masked", {31'd0, int_pend}, 32'd0);
        check("R6 mask keeps event", {31'd0, rd_data[19]}, 32'd1);
        reg_write(32'h2808_0000);
        check("R6 clear latch event", {31'd0, rd_data[19]}, 32'd0);
        reg_write(32'h0000_0000);

        // R5 fault while enabled (state 2 from the table)
        fault_n = 1'b0;
        step(); step();
        check("R5 connected fault", {30'd0, rd_data[20], rd_data[17]}, 32'd2);
        check("R3 fault sense", {31'd0, rd_data[6]}, 32'd0);
        check("R9 serr on fault", {31'd0, serr_pend}, 32'd1);
        reg_write(32'h0010_0000);
        check("R9 serr cleared", {31'd0, serr_pend}, 32'd0);
        fault_n = 1'b1;
        step(); step();
        check("R5 rise ignored", {27'd0, rd_data[20:16]}, 32'd0);

        // R5 fault while disabled
        cmd(2'd3, 2'd0, 2'd0);
        check("R2 disable", {30'd0, rd_data[1:0]}, 32'd3);
        fault_n = 1'b0;
        step(); step();
        check("R5 isolated fault", {30'd0, rd_data[20], rd_data[17]}, 32'd1);
        check("R9 no serr isolated", {31'd0, serr_pend}, 32'd0);
        check("R8 int isolated", {31'd0, int_pend}, 32'd1);
        reg_write(32'h0002_0000);
        fault_n = 1'b1;
        step(); step();

        // R6 set and clear in the same cycle
        presence = 2'd1;
        step();
        reg_write(32'h0001_0000);
        check("R6 set wins", {31'd0, rd_data[16]}, 32'd1);
        reg_write(32'h0000_0000);
        check("R6 zero keeps", {31'd0, rd_data[16]}, 32'd1);
        reg_write(32'h0001_0000);
        check("R6 final clear", {27'd0, rd_data[20:16]}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule